// File: doc/BRIEF.md
# Tagged Fully Associative TLB

This block is a small translation cache. It holds a set of mappings from virtual page numbers to physical frame numbers and searches all of them at once. Each stored mapping carries the identifier of the address space that owns it, so translations of several processes can sit side by side. Each mapping also carries read, write and execute permissions and a wired flag that pins it in place.

A lookup presents a page number, the current address-space identifier and the access type. One clock later the block reports a hit with the frame number, a permission fault, or a miss. On a miss an external walker fetches the translation and writes it through the refill port. When no free entry is left, a victim is chosen among the entries that are not wired. A parameter selects least-recently-used or pseudo-random choice. Flush inputs drop all entries that are not wired, or only those of one address space.

Top module: `tag_tlb`

## Requirements
- R1: A lookup hits when one valid entry has the same page number and identifier and allows the access. One clock later `lkp_hit_o` is 1 and `lkp_pfn_o` carries that entry's frame number.
- R2: A lookup that no valid entry matches gives `lkp_miss_o`=1 one clock later, with hit and fault at 0 and `lkp_pfn_o` at 0. A cycle without a lookup gives all three flags at 0.
- R3: An entry whose identifier differs from the lookup identifier never matches, even when its page number is equal.
- R4: The access type is encoded 0 read, 1 write, 2 execute, and 3 is reserved. The permission field has bit 0 read, bit 1 write and bit 2 execute. A matching entry that lacks the bit for the access, or any access of type 3, gives `lkp_fault_o`=1 with hit 0 and frame 0.
- R5: A refill whose page number and identifier are already present overwrites that entry in place and uses no other entry. Otherwise the refill goes to a free entry when one exists.
- R6: When every entry is valid, a refill replaces a non-wired entry. With `USE_LRU`=1 it replaces the one least recently touched; otherwise it replaces a pseudo-randomly chosen one.
- R7: An entry that is valid and wired is never chosen for replacement and is never removed by a flush.
- R8: `flush_all_i` invalidates every non-wired entry. A refill presented in the same cycle as any flush is ignored.
- R9: `flush_asid_i` invalidates only the non-wired entries whose identifier equals `flush_asid_val_i`.
- R10: When all entries are valid and wired, a refill that matches none of them is dropped. `overflow_o` is then 1 for exactly the following cycle.
- R11: Reset clears every entry, wired ones included, and drives all outputs to 0.
- R12: Under LRU, a hit (not a fault) and an accepted refill each mark their entry as most recent. When both occur in one cycle, the refill's entry is marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vpn_i | input | VPN_W | Lookup virtual page number |
| lkp_asid_i | input | ASID_W | Current address-space identifier |
| lkp_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| lkp_hit_o | output | 1 | Translation hit with permission |
| lkp_fault_o | output | 1 | Match found, access not permitted |
| lkp_miss_o | output | 1 | No matching entry |
| lkp_pfn_o | output | PFN_W | Frame number on hit, else 0 |
| refill_valid_i | input | 1 | Write a translation |
| refill_vpn_i | input | VPN_W | Refill page number |
| refill_asid_i | input | ASID_W | Refill identifier |
| refill_pfn_i | input | PFN_W | Refill frame number |
| refill_perm_i | input | 3 | Refill permissions: bit 0 R, bit 1 W, bit 2 X |
| refill_wired_i | input | 1 | Pin the entry against replacement and flush |
| flush_all_i | input | 1 | Invalidate all non-wired entries |
| flush_asid_i | input | 1 | Invalidate non-wired entries of one identifier |
| flush_asid_val_i | input | ASID_W | Identifier for the selective flush |
| overflow_o | output | 1 | Refill dropped because every entry is wired |

## Verification
A corrupted tag, identifier or permission field shows up at the lookup flags on the first lookup that uses the entry, one clock after it is issued. A wrong recency order or a wired entry lost in error stays hidden until the array is full. The next refill then removes the wrong entry, and the fault is seen only when a later lookup misses where a hit was due, or hits where a miss was due. The bench therefore runs the array full for long stretches and looks up every stored page after each eviction. This keeps the delay between a bad state and its symptom to a few cycles.

// File: rtl/tag_tlb_pkg.sv
package tag_tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_W = 3;

  function automatic logic perm_allows(input logic [PERM_W-1:0] perm, input logic [1:0] acc);
    case (acc)
      ACC_READ:  return perm[0];
      ACC_WRITE: return perm[1];
      ACC_EXEC:  return perm[2];
      default:   return 1'b0;
    endcase
  endfunction

  function automatic int idx_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IW    = tag_tlb_pkg::idx_w(N)
) (
  input  logic [N-1:0]             valid_i,
  input  logic [N-1:0][VPN_W-1:0]  vpn_i,
  input  logic [N-1:0][ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]         key_vpn_i,
  input  logic [ASID_W-1:0]        key_asid_i,
  output logic [N-1:0]             match_o,
  output logic                     any_o,
  output logic [IW-1:0]            idx_o
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) && (asid_i[g] == key_asid_i);
  end

  assign any_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match_o[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
  parameter int N       = 8,
  parameter bit USE_LRU = 1'b1,
  localparam int IW     = tag_tlb_pkg::idx_w(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  wired_i,
  input  logic          touch_v_i,
  input  logic [IW-1:0] touch_idx_i,
  output logic          victim_ok_o,
  output logic [IW-1:0] victim_idx_o
);

  if (USE_LRU) begin : g_lru
    // ages form a permutation 0..N-1; 0 is most recent
    logic [N-1:0][IW-1:0] age_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
      end else if (touch_v_i) begin
        for (int i = 0; i < N; i++) begin
          if (IW'(i) == touch_idx_i)            age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end

    always_comb begin
      logic [IW-1:0] best;
      victim_ok_o  = 1'b0;
      victim_idx_o = '0;
      best         = '0;
      for (int i = 0; i < N; i++) begin
        if (!wired_i[i] && (!victim_ok_o || age_q[i] > best)) begin
          victim_ok_o  = 1'b1;
          victim_idx_o = IW'(i);
          best         = age_q[i];
        end
      end
    end

    p_lru_touch_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      touch_v_i |=> age_q[$past(touch_idx_i)] == '0);

  end else begin : g_rand
    localparam logic [15:0] SEED = 16'hACE1;
    logic [15:0] lfsr_q, lfsr_nxt;
    logic        fb;
    int          start;

    assign fb       = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10] ^ (touch_v_i & ^touch_idx_i);
    assign lfsr_nxt = {lfsr_q[14:0], fb};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 lfsr_q <= SEED;
      else if (lfsr_nxt == 16'h0)  lfsr_q <= SEED;
      else                         lfsr_q <= lfsr_nxt;
    end

    assign start = int'(lfsr_q) % N;

    always_comb begin
      int j;
      victim_ok_o  = 1'b0;
      victim_idx_o = '0;
      for (int k = 0; k < N; k++) begin
        j = (start + k) % N;
        if (!victim_ok_o && !wired_i[j]) begin
          victim_ok_o  = 1'b1;
          victim_idx_o = IW'(j);
        end
      end
    end
  end

endmodule

// File: rtl/tag_tlb.sv
module tag_tlb #(
  parameter int N       = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  parameter bit USE_LRU = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  input  logic [ASID_W-1:0] lkp_asid_i,
  input  logic [1:0]        lkp_acc_i,
  output logic              lkp_hit_o,
  output logic              lkp_fault_o,
  output logic              lkp_miss_o,
  output logic [PFN_W-1:0]  lkp_pfn_o,
  input  logic              refill_valid_i,
  input  logic [VPN_W-1:0]  refill_vpn_i,
  input  logic [ASID_W-1:0] refill_asid_i,
  input  logic [PFN_W-1:0]  refill_pfn_i,
  input  logic [2:0]        refill_perm_i,
  input  logic              refill_wired_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_asid_val_i,
  output logic              overflow_o
);
  import tag_tlb_pkg::*;

  localparam int IW = idx_w(N);

  logic [N-1:0]                    valid_q, wired_q;
  logic [N-1:0][VPN_W-1:0]         vpn_q;
  logic [N-1:0][ASID_W-1:0]        asid_q;
  logic [N-1:0][PFN_W-1:0]         pfn_q;
  logic [N-1:0][PERM_W-1:0]        perm_q;

  logic [N-1:0]  lkp_match, rfl_match;
  logic          lkp_any, rfl_any, lkp_ok, lkp_hit;
  logic [IW-1:0] lkp_idx, rfl_idx;

  tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_lkp (
    .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(lkp_vpn_i), .key_asid_i(lkp_asid_i),
    .match_o(lkp_match), .any_o(lkp_any), .idx_o(lkp_idx)
  );

  tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_rfl (
    .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(refill_vpn_i), .key_asid_i(refill_asid_i),
    .match_o(rfl_match), .any_o(rfl_any), .idx_o(rfl_idx)
  );

  assign lkp_ok  = perm_allows(perm_q[lkp_idx], lkp_acc_i);
  assign lkp_hit = lkp_valid_i && lkp_any && lkp_ok;

  // lowest free slot
  logic          free_any;
  logic [IW-1:0] free_idx;
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  logic          vic_ok, flush_any, rfl_go, wr_en, rfl_drop, touch_v;
  logic [IW-1:0] vic_idx, wr_idx, touch_idx;

  assign flush_any = flush_all_i || flush_asid_i;
  assign rfl_go    = refill_valid_i && !flush_any;
  assign wr_en     = rfl_go && (rfl_any || free_any || vic_ok);
  assign rfl_drop  = rfl_go && !wr_en;
  assign wr_idx    = rfl_any ? rfl_idx : (free_any ? free_idx : vic_idx);
  assign touch_v   = wr_en || lkp_hit;
  assign touch_idx = wr_en ? wr_idx : lkp_idx;

  tlb_repl #(.N(N), .USE_LRU(USE_LRU)) u_repl (
    .clk_i, .rst_ni,
    .wired_i(wired_q),
    .touch_v_i(touch_v), .touch_idx_i(touch_idx),
    .victim_ok_o(vic_ok), .victim_idx_o(vic_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      wired_q <= '0;
      vpn_q   <= '0;
      asid_q  <= '0;
      pfn_q   <= '0;
      perm_q  <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (!wired_q[i] && (flush_all_i || (flush_asid_i && asid_q[i] == flush_asid_val_i)))
          valid_q[i] <= 1'b0;
      end
      if (wr_en) begin
        valid_q[wr_idx] <= 1'b1;
        wired_q[wr_idx] <= refill_wired_i;
        vpn_q[wr_idx]   <= refill_vpn_i;
        asid_q[wr_idx]  <= refill_asid_i;
        pfn_q[wr_idx]   <= refill_pfn_i;
        perm_q[wr_idx]  <= refill_perm_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lkp_hit_o   <= 1'b0;
      lkp_fault_o <= 1'b0;
      lkp_miss_o  <= 1'b0;
      lkp_pfn_o   <= '0;
      overflow_o  <= 1'b0;
    end else begin
      lkp_hit_o   <= lkp_hit;
      lkp_fault_o <= lkp_valid_i && lkp_any && !lkp_ok;
      lkp_miss_o  <= lkp_valid_i && !lkp_any;
      lkp_pfn_o   <= lkp_hit ? pfn_q[lkp_idx] : '0;
      overflow_o  <= rfl_drop;
    end
  end

  p_single_match_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lkp_match));

  p_result_follows_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_hit_o || lkp_fault_o || lkp_miss_o) |-> $past(lkp_valid_i));

  p_result_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lkp_hit_o, lkp_fault_o, lkp_miss_o}));

  p_fault_no_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_fault_o |-> lkp_pfn_o == '0);

  p_flush_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (valid_q & ~wired_q) == '0);

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> $past(refill_valid_i) && $past(valid_q & wired_q) == '1);

  for (genvar g = 0; g < N; g++) begin : g_wired_chk
    p_wired_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_q[g] && wired_q[g]) |=> valid_q[g]);
  end

endmodule

// File: tb/tb_tag_tlb.sv
`timescale 1ns/1ps
module tb_tag_tlb;
  localparam int N  = 8;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          lkp_v, rf_v, rf_w, fa, fs;
  logic [VW-1:0] lkp_vpn, rf_vpn;
  logic [AW-1:0] lkp_asid, rf_asid, fs_asid;
  logic [1:0]    lkp_acc;
  logic [PW-1:0] rf_pfn;
  logic [2:0]    rf_perm;
  logic          hit, fault, miss, ovf;
  logic [PW-1:0] pfn;

  tag_tlb #(.N(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW), .USE_LRU(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_v), .lkp_vpn_i(lkp_vpn), .lkp_asid_i(lkp_asid), .lkp_acc_i(lkp_acc),
    .lkp_hit_o(hit), .lkp_fault_o(fault), .lkp_miss_o(miss), .lkp_pfn_o(pfn),
    .refill_valid_i(rf_v), .refill_vpn_i(rf_vpn), .refill_asid_i(rf_asid),
    .refill_pfn_i(rf_pfn), .refill_perm_i(rf_perm), .refill_wired_i(rf_w),
    .flush_all_i(fa), .flush_asid_i(fs), .flush_asid_val_i(fs_asid),
    .overflow_o(ovf)
  );

  // reference model
  bit            mv[N], mw[N];
  logic [AW-1:0] ma[N];
  logic [VW-1:0] mvp[N];
  logic [PW-1:0] mpf[N];
  logic [2:0]    mpr[N];
  int            mst[N];
  int            stamp;
  int            nvec = 0, nbad = 0;
  bit            done = 0;

  function automatic bit ok_perm(logic [2:0] p, logic [1:0] a);
    if (a == 2'd0) return p[0];
    if (a == 2'd1) return p[1];
    if (a == 2'd2) return p[2];
    return 1'b0;
  endfunction

  function automatic int find(logic [VW-1:0] v, logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (mv[i] && mvp[i] == v && ma[i] == a) return i;
    return -1;
  endfunction

  function automatic int wired_cnt();
    int c = 0;
    for (int i = 0; i < N; i++) if (mv[i] && mw[i]) c++;
    return c;
  endfunction

  task automatic chk(input string tag, input string f, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s %s got %0h exp %0h at %0t", tag, f, got, exp, $time);
    end
  endtask

  task automatic clr_in();
    lkp_v = 0; lkp_vpn = '0; lkp_asid = '0; lkp_acc = '0;
    rf_v = 0; rf_vpn = '0; rf_asid = '0; rf_pfn = '0; rf_perm = '0; rf_w = 0;
    fa = 0; fs = 0; fs_asid = '0;
  endtask

  // one cycle with the inputs as set; called at a negedge
  task automatic step(input string tag);
    int li, wr, best;
    logic eh, ef, em, eo;
    logic [PW-1:0] ep;
    li = lkp_v ? find(lkp_vpn, lkp_asid) : -1;
    eh = lkp_v && li >= 0 && ok_perm(mpr[li], lkp_acc);
    ef = lkp_v && li >= 0 && !ok_perm(mpr[li], lkp_acc);
    em = lkp_v && li < 0;
    ep = eh ? mpf[li] : '0;
    wr = -1; eo = 0;
    if (rf_v && !fa && !fs) begin
      wr = find(rf_vpn, rf_asid);
      if (wr < 0) for (int i = 0; i < N; i++) if (wr < 0 && !mv[i]) wr = i;
      if (wr < 0) begin
        best = -1;
        for (int i = 0; i < N; i++)
          if (!mw[i] && (best < 0 || mst[i] < mst[best])) best = i;
        wr = best;
        eo = (best < 0);
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "hit", 32'(hit), 32'(eh));
    chk(tag, "fault", 32'(fault), 32'(ef));
    chk(tag, "miss", 32'(miss), 32'(em));
    chk(tag, "pfn", 32'(pfn), 32'(ep));
    chk(tag, "overflow", 32'(ovf), 32'(eo));
    for (int i = 0; i < N; i++)
      if (!mw[i] && (fa || (fs && ma[i] == fs_asid))) mv[i] = 0;
    if (wr >= 0) begin
      mv[wr] = 1; mw[wr] = rf_w; ma[wr] = rf_asid; mvp[wr] = rf_vpn;
      mpf[wr] = rf_pfn; mpr[wr] = rf_perm; mst[wr] = ++stamp;
    end else if (eh) begin
      mst[li] = ++stamp;
    end
    clr_in();
  endtask

  task automatic lookup(input int v, input int a, input int acc, input string tag);
    lkp_v = 1; lkp_vpn = VW'(v); lkp_asid = AW'(a); lkp_acc = 2'(acc);
    step(tag);
  endtask

  task automatic refill(input int v, input int a, input int p, input int perm, input bit w, input string tag);
    rf_v = 1; rf_vpn = VW'(v); rf_asid = AW'(a); rf_pfn = PW'(p); rf_perm = 3'(perm); rf_w = w;
    step(tag);
  endtask

  task automatic do_reset();
    rst_n = 0;
    clr_in();
    for (int i = 0; i < N; i++) begin mv[i] = 0; mw[i] = 0; mst[i] = 0; end
    stamp = 0;
    repeat (2) @(negedge clk);
    chk("R11", "hit", 32'(hit), 0);
    chk("R11", "fault", 32'(fault), 0);
    chk("R11", "miss", 32'(miss), 0);
    chk("R11", "pfn", 32'(pfn), 0);
    chk("R11", "overflow", 32'(ovf), 0);
    rst_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    clr_in();
    @(negedge clk);
    do_reset();

    // R1 R2 R3 R4 basics
    refill(5, 1, 'h123, 3'b111, 0, "R5");
    lookup(5, 1, 0, "R1");
    lookup(5, 1, 2, "R1");
    lookup(5, 2, 0, "R3");
    lookup(6, 1, 0, "R2");
    step("R2");
    refill(7, 1, 'h77, 3'b001, 0, "R5");
    lookup(7, 1, 1, "R4");
    lookup(7, 1, 2, "R4");
    lookup(7, 1, 3, "R4");
    lookup(7, 1, 0, "R4");

    // R5 in-place update
    refill(5, 1, 'h456, 3'b111, 0, "R5");
    lookup(5, 1, 0, "R5");
    for (int v = 10; v < 16; v++) refill(v, 1, 'h1000 + v, 3'b011, 0, "R5");
    for (int v = 5; v < 16; v++) lookup(v, 1, 0, "R5");

    // R6 R12 LRU replacement with hits reordering recency
    lookup(10, 1, 0, "R12");
    refill(20, 1, 'h2020, 3'b111, 0, "R6");
    refill(21, 1, 'h2121, 3'b111, 0, "R6");
    for (int v = 5; v < 22; v++) lookup(v, 1, 0, "R6");
    lookup(13, 1, 0, "R12");
    lkp_v = 1; lkp_vpn = VW'(14); lkp_asid = AW'(1); lkp_acc = 2'd0;
    rf_v = 1; rf_vpn = VW'(22); rf_asid = AW'(1); rf_pfn = PW'('h2222); rf_perm = 3'b111;
    step("R12");
    refill(23, 1, 'h2323, 3'b111, 0, "R12");
    for (int v = 5; v < 24; v++) lookup(v, 1, 0, "R12");

    // R9 per-identifier flush
    refill(30, 2, 'h3030, 3'b111, 0, "R9");
    fs = 1; fs_asid = AW'(1); step("R9");
    for (int v = 5; v < 31; v++) lookup(v, 1, 0, "R9");
    lookup(30, 2, 0, "R9");

    // R7 R8 wired entries
    do_reset();
    refill(40, 3, 'h4040, 3'b111, 1, "R7");
    for (int v = 41; v < 52; v++) refill(v, 3, 'h4000 + v, 3'b111, 0, "R7");
    for (int v = 40; v < 52; v++) lookup(v, 3, 0, "R7");
    fa = 1; step("R8");
    lookup(40, 3, 0, "R7");
    lookup(51, 3, 0, "R8");
    fa = 1; rf_v = 1; rf_vpn = VW'(55); rf_asid = AW'(3); rf_pfn = PW'('h55); rf_perm = 3'b111;
    step("R8");
    lookup(55, 3, 0, "R8");
    refill(56, 4, 'h56, 3'b111, 0, "R9");
    fs = 1; fs_asid = AW'(3); rf_v = 1; rf_vpn = VW'(57); rf_asid = AW'(4); rf_perm = 3'b111;
    step("R8");
    lookup(57, 4, 0, "R8");
    lookup(56, 4, 0, "R9");
    lookup(40, 3, 0, "R7");

    // R10 all wired
    do_reset();
    for (int v = 60; v < 60 + N; v++) refill(v, 5, 'h6000 + v, 3'b101, 1, "R10");
    refill(70, 5, 'h7070, 3'b111, 0, "R10");
    step("R10");
    lookup(70, 5, 0, "R10");
    refill(60, 5, 'h6666, 3'b111, 1, "R10");
    lookup(60, 5, 1, "R10");

    // R11 reset drops wired entries
    do_reset();
    lookup(60, 5, 0, "R11");
    lookup(61, 5, 0, "R11");

    // random phase
    seed = $urandom(32'd20240);
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 10 < 7) begin
        lkp_v = 1; lkp_vpn = VW'($urandom % 12); lkp_asid = AW'($urandom % 3);
        lkp_acc = 2'($urandom % 4);
      end
      if ($urandom % 10 < 3) begin
        rf_v = 1; rf_vpn = VW'($urandom % 12); rf_asid = AW'($urandom % 3);
        rf_pfn = PW'($urandom); rf_perm = 3'($urandom % 8);
        rf_w = (wired_cnt() < 3) && ($urandom % 16 == 0);
      end
      if ($urandom % 64 == 0) fa = 1;
      if ($urandom % 48 == 0) begin fs = 1; fs_asid = AW'($urandom % 3); end
      step("R6");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule